// File: doc/BRIEF.md
# Serial EEPROM Read Master

This block is the read half of a two-wire serial EEPROM controller. It assumes the EEPROM's internal address pointer was loaded by an earlier write phase. After that, one command fetches a run of bytes starting at that pointer. The block generates the clock line from the system clock through a programmable quarter-period divider. It issues a start condition and a read control byte, checks for the slave's acknowledge, and shifts in data bytes most significant bit first. It acknowledges every byte except the last. The last byte gets a no-acknowledge and then a stop condition.

Each received byte appears on a parallel output with a one-cycle valid strobe. Two addressing modes are supported, and they differ only in the control byte. In single-byte addressing, the three select bits carry the top memory-address bits. In double-byte addressing, those bits are sent as zero. If the slave does not acknowledge the control byte, the block raises a sticky timeout flag and still ends with a stop condition. Both bus lines are open-drain: an output enable pulls the line low, and a released line reads back high.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o and rx_valid_o are low, and scl_oe_o and sda_oe_o are low (both lines released).
- R2: The control byte is sent MSB first and reads 1,0,1,0, then the select field, then 1 (read). In single-byte mode (dbl_addr_i=0) the select field is addr_hi_i[2:0], sent bit 2 first.
- R3: In double-byte mode (dbl_addr_i=1) the select field is 000.
- R4: Each transfer has exactly one start (SDA falls while SCL is high) and one stop (SDA rises while SCL is high). At every other time, SDA changes only while SCL is low.
- R5: Data bits are sampled in the middle of the SCL high phase, MSB first. Each byte appears on rx_data_o together with a one-cycle rx_valid_o pulse.
- R6: The master drives ACK (SDA low) after each received byte except the last. After the last byte it drives NACK (SDA released), followed by the stop.
- R7: The byte count is latched when a command is accepted. A count of N gives exactly N rx_valid_o pulses, and a count of 1 gives a single-byte read.
- R8: If the slave leaves SDA high in the control-byte acknowledge slot, no data is read, timeout_o is set, and a stop is still generated before done.
- R9: timeout_o stays set until the next command is accepted, which clears it.
- R10: A command with byte_cnt_i equal to 0 is ignored: busy_o stays low and timeout_o is unchanged.
- R11: busy_o is high from the cycle after acceptance until the stop completes. done_o pulses for one cycle as busy_o falls.
- R12: One SCL period lasts 4*(clk_div_i+1) system clocks, with clk_div_i latched at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Start-read request, taken while idle |
| byte_cnt_i | input | CNT_W | Number of bytes to read |
| addr_hi_i | input | 3 | Memory address bits 10..8 for single-byte mode |
| dbl_addr_i | input | 1 | 1 selects double-byte addressing mode |
| clk_div_i | input | DIV_W | Quarter SCL period minus one, in system clocks |
| scl_i | input | 1 | SCL line read back |
| sda_i | input | 1 | SDA line read back |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| timeout_o | output | 1 | Sticky slave no-acknowledge flag |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | rx_data_o strobe |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The assertions assume the following about the inputs:
- No other device drives SCL.
- The slave changes SDA only while SCL is low.
- clk_div_i is stable enough to be captured in the accepting cycle.

The bench's slave model reacts to bus edges only after SCL has fallen, and it releases SDA outside its own slots. Random commands are issued only while busy_o is low. These use byte counts from 1 to 6 and divider values from 0 to 3, with an occasional slave that refuses the control byte. Directed cases cover a single-byte read, double-byte mode, a refused control byte, and a zero count.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_CTRL, ST_CACK, ST_DATA, ST_MACK, ST_STOP
  } rd_state_e;
  localparam logic [3:0] CTRL_CODE = 4'b1010;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_rd_qtick.sv
module i2c_rd_qtick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= div_i;
    else if (cnt_q == '0)   cnt_q <= div_i;
    else                    cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = run_i && (cnt_q == '0);

  // quarter counter never exceeds the latched divider while running
  assert_cnt_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) |-> cnt_q <= div_i);
endmodule

// File: rtl/i2c_rd_rxshift.sv
module i2c_rd_rxshift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader
  import i2c_rd_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [2:0]        addr_hi_i,
  input  logic              dbl_addr_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(BYTE_W - 1);

  rd_state_e         state_q;
  logic [1:0]        q_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  left_q;
  logic [2:0]        sel_q;
  logic [DIV_W-1:0]  div_q;
  logic              ack_ok_q;
  logic              timeout_q, done_q, rx_valid_q;
  logic [BYTE_W-1:0] rx_data_q;

  logic              tick, accept, last_byte, rx_shift;
  logic              scl_lvl, sda_lvl;
  logic [DIV_W-1:0]  div_sel;
  logic [BYTE_W-1:0] ctrl_byte, shreg;

  assign accept    = (state_q == ST_IDLE) && cmd_valid_i && (byte_cnt_i != '0);
  assign last_byte = (left_q <= CNT_W'(1));
  assign ctrl_byte = {CTRL_CODE, sel_q, 1'b1};
  assign div_sel   = (state_q == ST_IDLE) ? clk_div_i : div_q;
  assign rx_shift  = tick && (q_q == 2'd2) && (state_q == ST_DATA);

  i2c_rd_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .div_i  (div_sel),
    .tick_o (tick)
  );

  i2c_rd_rxshift #(.W(BYTE_W)) u_rxshift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (rx_shift),
    .bit_i   (sda_i),
    .data_o  (shreg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      q_q        <= '0;
      bit_q      <= '0;
      left_q     <= '0;
      sel_q      <= '0;
      div_q      <= '0;
      ack_ok_q   <= 1'b0;
      timeout_q  <= 1'b0;
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      if (accept) begin
        state_q   <= ST_START;
        q_q       <= '0;
        left_q    <= byte_cnt_i;
        sel_q     <= dbl_addr_i ? 3'b000 : addr_hi_i;
        div_q     <= clk_div_i;
        timeout_q <= 1'b0;
      end else if (tick) begin
        q_q <= q_q + 2'd1;
        if (q_q == 2'd2 && state_q == ST_CACK) ack_ok_q <= !sda_i;
        if (q_q == 2'd3) begin
          unique case (state_q)
            ST_START: begin
              state_q <= ST_CTRL;
              bit_q   <= MSB_IDX;
            end
            ST_CTRL: begin
              if (bit_q == '0) state_q <= ST_CACK;
              else             bit_q   <= bit_q - BIT_W'(1);
            end
            ST_CACK: begin
              if (ack_ok_q) begin
                state_q <= ST_DATA;
                bit_q   <= MSB_IDX;
              end else begin
                timeout_q <= 1'b1;
                state_q   <= ST_STOP;
              end
            end
            ST_DATA: begin
              if (bit_q == '0) begin
                state_q    <= ST_MACK;
                rx_valid_q <= 1'b1;
                rx_data_q  <= shreg;
              end else begin
                bit_q <= bit_q - BIT_W'(1);
              end
            end
            ST_MACK: begin
              if (!last_byte) begin
                left_q  <= left_q - CNT_W'(1);
                state_q <= ST_DATA;
                bit_q   <= MSB_IDX;
              end else begin
                state_q <= ST_STOP;
              end
            end
            ST_STOP: begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // line levels: quarter 0/1 SCL low, 2/3 high
  always_comb begin
    scl_lvl = 1'b1;
    sda_lvl = 1'b1;
    unique case (state_q)
      ST_START: begin
        scl_lvl = (q_q != 2'd3);
        sda_lvl = (q_q == 2'd0);
      end
      ST_CTRL: begin
        scl_lvl = q_q[1];
        sda_lvl = ctrl_byte[bit_q];
      end
      ST_CACK, ST_DATA: scl_lvl = q_q[1];
      ST_MACK: begin
        scl_lvl = q_q[1];
        sda_lvl = last_byte;
      end
      ST_STOP: begin
        scl_lvl = q_q[1];
        sda_lvl = (q_q == 2'd3);
      end
      default: ;
    endcase
  end

  assign scl_oe_o   = !scl_lvl;
  assign sda_oe_o   = !sda_lvl;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign timeout_o  = timeout_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;

  logic scl_unused;
  assign scl_unused = scl_i;

  assert_sda_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_lvl && $past(scl_lvl) && (sda_lvl != $past(sda_lvl))
      |-> (state_q == ST_START || state_q == ST_STOP));
  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_timeout_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !timeout_o);
  assert_timeout_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !accept |=> timeout_o);
  assert_valid_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> busy_o);
  assert_zero_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_valid_i && (byte_cnt_i == '0) |=> !busy_o);
endmodule

// File: tb/i2c_eeprom_reader_tb.sv
module i2c_eeprom_reader_tb_top;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic [2:0]       addr_hi = '0;
  logic             dbl_addr = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic busy, done, timeout, rx_valid, scl_oe, sda_oe;
  logic [7:0] rx_data;
  logic s_pull = 1'b0;
  logic scl_ln, sda_ln;

  assign scl_ln = !scl_oe;
  assign sda_ln = !(sda_oe || s_pull);

  i2c_eeprom_reader #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .byte_cnt_i(byte_cnt),
    .addr_hi_i(addr_hi), .dbl_addr_i(dbl_addr), .clk_div_i(clk_div),
    .scl_i(scl_ln), .sda_i(sda_ln), .busy_o(busy), .done_o(done),
    .timeout_o(timeout), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [7:0] exp_data(logic [7:0] salt, int k);
    return salt ^ 8'((k * 29) + 3);
  endfunction
  function automatic logic [7:0] exp_ctrl(logic [2:0] a, bit dbl);
    return {4'b1010, (dbl ? 3'b000 : a), 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural EEPROM slave
  int s_phase = 0, s_bits = 0, s_idx = 0, cyc = 0, rise_cnt = 0;
  int n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0;
  int rise_t[3];
  logic [7:0] s_ctrl = '0, s_tx = '0, s_salt = '0;
  bit s_nack_mode = 0, s_last_ack = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (p_scl && scl_ln && p_sda && !sda_ln) begin
      n_start++; s_phase = 1; s_bits = 0; s_ctrl = '0;
    end else if (p_scl && scl_ln && !p_sda && sda_ln) begin
      n_stop++; s_phase = 0; s_pull <= 1'b0;
    end else if (!p_scl && scl_ln) begin
      if (rise_cnt < 3) rise_t[rise_cnt] = cyc;
      rise_cnt++;
      if (s_phase == 1) begin
        s_ctrl = {s_ctrl[6:0], sda_ln}; s_bits++;
      end else if (s_phase == 4) begin
        s_last_ack = !sda_ln;
        if (!sda_ln) n_mack++; else n_mnack++;
      end
    end else if (p_scl && !scl_ln) begin
      case (s_phase)
        1: if (s_bits == 8) begin s_phase = 2; s_pull <= !s_nack_mode; end
        2: begin
          if (s_nack_mode) s_phase = 0;
          else begin
            s_phase = 3; s_bits = 0; s_tx = exp_data(s_salt, s_idx); s_pull <= !s_tx[7];
          end
        end
        3: begin
          s_bits++;
          if (s_bits == 8) begin s_phase = 4; s_pull <= 1'b0; end
          else s_pull <= !s_tx[7 - s_bits];
        end
        4: begin
          if (s_last_ack) begin
            s_idx++; s_tx = exp_data(s_salt, s_idx); s_bits = 0; s_phase = 3;
            s_pull <= !s_tx[7];
          end else s_phase = 0;
        end
        default: ;
      endcase
    end
    p_scl = scl_ln;
    p_sda = sda_ln;
  end

  task automatic run_xfer(input int cnt, input logic [2:0] a, input bit dbl,
                          input int div, input bit nack);
    int got = 0;
    int waited = 0;
    s_nack_mode = nack; s_idx = 0; s_salt = 8'($urandom);
    n_start = 0; n_stop = 0; n_mack = 0; n_mnack = 0; rise_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; byte_cnt = CNT_W'(cnt); addr_hi = a; dbl_addr = dbl;
    clk_div = DIV_W'(div);
    @(negedge clk);
    cmd_valid = 1'b0; clk_div = 8'hff;
    check(busy == 1'b1, "R11 busy after accept", busy, 1);
    check(timeout == 1'b0, "R9 timeout cleared on accept", timeout, 0);
    while (!done && waited < 20000) begin
      if (rx_valid) begin
        check(rx_data == exp_data(s_salt, got), "R5 rx byte", rx_data, exp_data(s_salt, got));
        got++;
      end
      @(negedge clk);
      waited++;
    end
    check(waited < 20000, "R11 transfer finishes", waited, 0);
    check(busy == 1'b0, "R11 busy low at done", busy, 0);
    check(s_ctrl == exp_ctrl(a, dbl), dbl ? "R3 control byte" : "R2 control byte",
          s_ctrl, exp_ctrl(a, dbl));
    check(got == (nack ? 0 : cnt), nack ? "R8 no data on nack" : "R7 byte count",
          got, nack ? 0 : cnt);
    if (!nack) begin
      check(n_mack == cnt - 1, "R6 master acks", n_mack, cnt - 1);
      check(n_mnack == 1, "R6 final nack", n_mnack, 1);
    end
    check(timeout == nack, "R8 timeout flag", timeout, nack);
    check(n_start == 1 && n_stop == 1, "R4 one start one stop", n_start * 10 + n_stop, 11);
    check(rise_t[2] - rise_t[1] == 4 * (div + 1), "R12 scl period",
          rise_t[2] - rise_t[1], 4 * (div + 1));
    check(!scl_oe && !sda_oe, "R4 bus released after stop", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!busy && !done && !timeout && !rx_valid, "R1 reset outputs",
          {busy, done, timeout, rx_valid}, 0);
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_xfer(1, 3'b101, 1'b0, 0, 1'b0);   // R7 single read, R2 select bits
    run_xfer(1, 3'b111, 1'b1, 1, 1'b0);   // R3 double mode
    run_xfer(4, 3'b010, 1'b0, 2, 1'b0);   // R6 sequential
    run_xfer(3, 3'b001, 1'b0, 1, 1'b1);   // R8 refused control byte
    repeat (50) @(negedge clk);
    check(timeout == 1'b1, "R9 timeout sticky", timeout, 1);
    cmd_valid = 1'b1; byte_cnt = '0; clk_div = 8'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R10 zero count ignored", busy, 0);
    check(timeout == 1'b1, "R10 timeout untouched", timeout, 1);
    check(!scl_oe && !sda_oe, "R10 bus idle", {scl_oe, sda_oe}, 0);
    run_xfer(2, 3'b110, 1'b0, 0, 1'b0);   // R9 clear on accept

    for (int i = 0; i < 20; i++) begin
      run_xfer(int'($urandom_range(6, 1)), 3'($urandom), 1'($urandom),
               int'($urandom_range(3, 0)), ($urandom_range(7, 0) == 0));
      repeat (int'($urandom_range(5, 1))) @(negedge clk);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule